// File: doc/BRIEF.md
# Flash Command Interface State Machine

This block is the command-decoding front end of a parallel NOR flash device, wrapped around a small simulated array. Software talks to it only through bus writes (a one-cycle `wr_en` strobe with address and data) and through a combinational read port. The low byte of each write is decoded as a command code. The sequences it accepts are: single-word program, buffered multi-word program, block erase with a confirm code, and setting or clearing per-block lock bits under a write-protect input. Program and erase times are replaced by a fixed count of `OP_CYCLES` clocks, during which `busy` is high.

The controller is a single finite state machine. `S_ARRAY` and `S_STATUS` are the two idle read modes. From either, `FFh` leads to `S_ARRAY`, `70h` leads to `S_STATUS`, and `50h` clears the sticky status bits without leaving the mode. `40h` or `10h` leads to `S_PGM_SETUP`. `E8h` leads to `S_BUF_COUNT`, and `20h` to `S_ERS_SETUP`. `60h` leads to `S_LCK_SETUP`. The buffered path runs `S_BUF_COUNT` → `S_BUF_DATA` (held for N+1 writes) → `S_BUF_CONFIRM`. Every setup state leaves either to `S_BUSY`, when the operation is accepted, or to `S_STATUS`, when it is refused or the sequence is bad. `S_BUSY` always returns to `S_STATUS`. The array is split into blocks of 2^`OFF_W` words, each with a lock bit. A lock bit of 0 means the block is locked. Programming only clears bits (new word = old AND data), and erase sets a whole block to all ones.

Status byte layout: bit 7 ready, bit 5 erase fail, bit 4 program fail, bit 3 sequence error, bit 1 lock violation. Bits 5, 4, 3 and 1 are sticky. The other bits read 0, and the upper byte of `rd_data` reads 0 in any status mode.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset every array word reads FFFFh, `busy` is low, every block is unlocked, the block is in array read mode, and the status byte is 80h.
- R2: Commands are decoded from `wr_data[7:0]` alone; the upper byte has no effect. In an idle mode, any code other than FFh, 70h, 50h, 40h, 10h, E8h, 20h and 60h changes neither the mode nor the array.
- R3: After 40h or 10h, the next write programs its address with its data as old AND data. The array word holds its result once `busy` has fallen.
- R4: E8h enters a buffer state whose reads return 0080h (bit 7 = a buffer is free). The next write's low byte is N. The following N+1 writes each load an address and data, and D0h then programs all of them. A code other than D0h at that step, or N+1 greater than `BUF_DEPTH`, sets bit 3 and leaves the array unchanged.
- R5: 20h followed by D0h sets every word of the addressed block to FFFFh and leaves all other blocks unchanged. Any other second code sets bit 3 and erases nothing.
- R6: A program, buffered program or erase that touches a locked block while `wp` is low is refused. `busy` stays low, the array is unchanged, and the status gains bits 4 and 1 (program) or bits 5 and 1 (erase). With `wp` high the same operation proceeds.
- R7: 60h followed by 01h locks only the addressed block, and 60h followed by D0h unlocks all blocks; both act only if `wp` is high. With `wp` low, set sets bits 4 and 1 and clear sets bits 5 and 1. Any other second code sets bit 3.
- R8: An accepted operation holds `busy` high for `OP_CYCLES` clocks, with status bit 7 reading 0. Bus writes during that time are ignored, and afterwards the block is in status read mode reading ready.
- R9: Failure bits accumulate until 50h is written; 50h clears bits 5, 4, 3 and 1.
- R10: In array mode `rd_data` is the word at `rd_addr`. In status mode, in any setup state, and during `busy`, `rd_data` is the status byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | ADDR_W | Word address of the bus write |
| wr_data | input | DATA_W | Bus write data; low byte carries the command code |
| wp | input | 1 | Write-protect; high permits lock changes and writes to locked blocks |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Array word or status byte, depending on mode |
| busy | output | 1 | High while an accepted operation runs |

## Verification
The hardest situations to reach are the lock-enforcement corners. A lock bit cannot be read back directly, so its state is seen only through whether a later program or erase is refused. The stimulus reaches these corners by changing `wp` between the setup, lock-set and lock-clear sequences. It then probes the same block, and a neighbouring block, with single, buffered and erase operations, and checks both the sticky status bits and the array contents. The buffered path is swept over every count from 0 to `BUF_DEPTH-1`, with addresses in a scrambled order. Each count is checked for exactly the loaded words changing, followed by an abort at the confirm step and an over-long count.

// File: rtl/fci_pkg.sv
package fci_pkg;

    typedef enum logic [3:0] {
        S_ARRAY,
        S_STATUS,
        S_PGM_SETUP,
        S_BUF_COUNT,
        S_BUF_DATA,
        S_BUF_CONFIRM,
        S_ERS_SETUP,
        S_LCK_SETUP,
        S_BUSY
    } fci_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_PGM,
        OP_BUF,
        OP_ERS,
        OP_LSET,
        OP_LCLR
    } fci_op_e;

    localparam logic [7:0] C_READ_ARRAY = 8'hFF;
    localparam logic [7:0] C_READ_STAT  = 8'h70;
    localparam logic [7:0] C_CLR_STAT   = 8'h50;
    localparam logic [7:0] C_PGM_A      = 8'h40;
    localparam logic [7:0] C_PGM_B      = 8'h10;
    localparam logic [7:0] C_BUF_WR     = 8'hE8;
    localparam logic [7:0] C_ERASE      = 8'h20;
    localparam logic [7:0] C_LOCK       = 8'h60;
    localparam logic [7:0] C_CONFIRM    = 8'hD0;
    localparam logic [7:0] C_LOCK_SET   = 8'h01;

    localparam logic [7:0] ST_READY     = 8'h80;
    localparam logic [7:0] ST_ERS_FAIL  = 8'h20;
    localparam logic [7:0] ST_PGM_FAIL  = 8'h10;
    localparam logic [7:0] ST_SEQ_ERR   = 8'h08;
    localparam logic [7:0] ST_LOCK_VIOL = 8'h02;
    localparam logic [7:0] ST_STICKY    = 8'h3A;

    function automatic logic is_idle_cmd(input logic [7:0] c);
        return (c == C_READ_ARRAY) || (c == C_READ_STAT) || (c == C_CLR_STAT) ||
               (c == C_PGM_A) || (c == C_PGM_B) || (c == C_BUF_WR) ||
               (c == C_ERASE) || (c == C_LOCK);
    endfunction

endpackage

// File: rtl/fci_array.sv
module fci_array #(
    parameter int ADDR_W = 6,
    parameter int OFF_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pgm_en,
    input  logic [ADDR_W-1:0]           pgm_addr,
    input  logic [DATA_W-1:0]           pgm_data,
    input  logic                        ers_en,
    input  logic [ADDR_W-OFF_W-1:0]     ers_blk,
    input  logic                        lset_en,
    input  logic [ADDR_W-OFF_W-1:0]     lset_blk,
    input  logic                        lclr_en,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [DATA_W-1:0]           rd_data,
    output logic [(1<<(ADDR_W-OFF_W))-1:0] lock_n
);
    localparam int WORDS = 1 << ADDR_W;
    localparam int BLK_W = ADDR_W - OFF_W;

    logic [DATA_W-1:0] mem [WORDS];
    logic [DATA_W-1:0] cur_word;
    logic [ADDR_W-1:0] ers_first;

    assign cur_word  = mem[pgm_addr];
    assign ers_first = {ers_blk, {OFF_W{1'b0}}};
    assign rd_data   = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '1;
            lock_n <= '1;
        end else begin
            if (pgm_en) mem[pgm_addr] <= cur_word & pgm_data;
            if (ers_en) begin
                for (int i = 0; i < WORDS; i++)
                    if (BLK_W'(i >> OFF_W) == ers_blk) mem[i] <= '1;
            end
            if (lclr_en)      lock_n <= '1;
            else if (lset_en) lock_n[lset_blk] <= 1'b0;
        end
    end

    // R3: programming only clears bits
    a_r3_program_ands: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_en && !ers_en) |=> (mem[$past(pgm_addr)] == ($past(cur_word) & $past(pgm_data))))
        else $error("a_r3_program_ands");

    // R5: erased block reads all ones
    a_r5_erase_ones: assert property (@(posedge clk) disable iff (!rst_n)
        ers_en |=> (mem[$past(ers_first)] == '1))
        else $error("a_r5_erase_ones");

    // R7: clear unlocks every block
    a_r7_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        lclr_en |=> (&lock_n))
        else $error("a_r7_clear_all");

endmodule

// File: rtl/fci_wbuf.sv
module fci_wbuf #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr_i,
    input  logic                       push_i,
    input  logic [ADDR_W-1:0]          push_addr,
    input  logic [DATA_W-1:0]          push_data,
    input  logic [$clog2(DEPTH)-1:0]   rd_idx,
    output logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    output logic [$clog2(DEPTH):0]     count_o
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = IDX_W + 1;

    logic [ADDR_W-1:0] addr_mem [DEPTH];
    logic [DATA_W-1:0] data_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (clr_i) begin
            count_o <= '0;
        end else if (push_i) begin
            addr_mem[IDX_W'(count_o)] <= push_addr;
            data_mem[IDX_W'(count_o)] <= push_data;
            count_o <= count_o + 1'b1;
        end
    end

    assign rd_addr = addr_mem[rd_idx];
    assign rd_data = data_mem[rd_idx];

    // R4: the sequencer never loads more than the buffer holds
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (count_o < CNT_W'(DEPTH)))
        else $error("a_r4_no_overflow");

endmodule

// File: rtl/fci_status.sv
module fci_status
    import fci_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] set_i,
    input  logic       clr_i,
    input  logic       ready_i,
    output logic [7:0] status_o
);
    logic [7:0] sticky_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      sticky_q <= '0;
        else if (clr_i)  sticky_q <= '0;
        else             sticky_q <= sticky_q | (set_i & ST_STICKY);
    end

    assign status_o = (ready_i ? ST_READY : 8'h00) | sticky_q;

    // R9: clear-status empties every sticky bit
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && set_i == 8'h00) |=> ((status_o & ST_STICKY) == 8'h00))
        else $error("a_r9_clear_empties");

    // R9: sticky bits never fall without a clear
    a_r9_bits_stick: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)))
        else $error("a_r9_bits_stick");

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
    import fci_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int OFF_W     = 4,
    parameter int DATA_W    = 16,
    parameter int BUF_DEPTH = 16,
    parameter int OP_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wp,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy
);
    localparam int BLK_W = ADDR_W - OFF_W;
    localparam int NBLK  = 1 << BLK_W;
    localparam int IDX_W = $clog2(BUF_DEPTH);
    localparam int CNT_W = IDX_W + 1;
    localparam int CYC_W = $clog2(OP_CYCLES + 1);
    localparam logic [CYC_W-1:0] LAST  = CYC_W'(OP_CYCLES - 1);
    localparam logic [7:0]       MAX_N = 8'(BUF_DEPTH - 1);

    fci_state_e        state_q, state_d;
    fci_op_e           op_q, op_d;
    logic [ADDR_W-1:0] tgt_addr_q, tgt_addr_d;
    logic [DATA_W-1:0] tgt_data_q, tgt_data_d;
    logic [CYC_W-1:0]  cnt_q, cnt_d;
    logic [7:0]        left_q, left_d;
    logic              hit_q, hit_d;

    logic [7:0]        cmd, st_set, status;
    logic              st_clr, buf_clr, buf_push, at_last;
    logic              a_pgm, a_ers, a_lset, a_lclr;
    logic [ADDR_W-1:0] a_pgm_addr, buf_rd_addr;
    logic [DATA_W-1:0] a_pgm_data, buf_rd_data, arr_rd;
    logic [NBLK-1:0]   lock_n;
    logic [BLK_W-1:0]  wr_blk, tgt_blk;
    logic              wr_locked;
    logic [CNT_W-1:0]  buf_cnt;

    assign cmd       = wr_data[7:0];
    assign wr_blk    = wr_addr[ADDR_W-1:OFF_W];
    assign tgt_blk   = tgt_addr_q[ADDR_W-1:OFF_W];
    assign wr_locked = !lock_n[wr_blk];
    assign at_last   = (cnt_q == LAST);
    assign busy      = (state_q == S_BUSY);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_ARRAY;
            op_q       <= OP_NONE;
            tgt_addr_q <= '0;
            tgt_data_q <= '0;
            cnt_q      <= '0;
            left_q     <= '0;
            hit_q      <= 1'b0;
        end else begin
            state_q    <= state_d;
            op_q       <= op_d;
            tgt_addr_q <= tgt_addr_d;
            tgt_data_q <= tgt_data_d;
            cnt_q      <= cnt_d;
            left_q     <= left_d;
            hit_q      <= hit_d;
        end
    end

    // next state
    always_comb begin
        state_d    = state_q;
        op_d       = op_q;
        tgt_addr_d = tgt_addr_q;
        tgt_data_d = tgt_data_q;
        cnt_d      = cnt_q;
        left_d     = left_q;
        hit_d      = hit_q;
        st_set     = 8'h00;
        st_clr     = 1'b0;
        buf_clr    = 1'b0;
        buf_push   = 1'b0;
        unique case (state_q)
            S_ARRAY, S_STATUS: if (wr_en) begin
                case (cmd)
                    C_READ_ARRAY:     state_d = S_ARRAY;
                    C_READ_STAT:      state_d = S_STATUS;
                    C_CLR_STAT:       st_clr  = 1'b1;
                    C_PGM_A, C_PGM_B: state_d = S_PGM_SETUP;
                    C_BUF_WR: begin
                        state_d = S_BUF_COUNT;
                        buf_clr = 1'b1;
                    end
                    C_ERASE:          state_d = S_ERS_SETUP;
                    C_LOCK:           state_d = S_LCK_SETUP;
                    default: ;
                endcase
            end
            S_PGM_SETUP: if (wr_en) begin
                if (wr_locked && !wp) begin
                    st_set  = ST_PGM_FAIL | ST_LOCK_VIOL;
                    state_d = S_STATUS;
                end else begin
                    op_d       = OP_PGM;
                    tgt_addr_d = wr_addr;
                    tgt_data_d = wr_data;
                    cnt_d      = '0;
                    state_d    = S_BUSY;
                end
            end
            S_BUF_COUNT: if (wr_en) begin
                if (cmd > MAX_N) begin
                    st_set  = ST_SEQ_ERR;
                    state_d = S_STATUS;
                end else begin
                    left_d  = cmd;
                    hit_d   = 1'b0;
                    state_d = S_BUF_DATA;
                end
            end
            S_BUF_DATA: if (wr_en) begin
                buf_push = 1'b1;
                if (wr_locked) hit_d = 1'b1;
                if (left_q == 8'd0) state_d = S_BUF_CONFIRM;
                else                left_d  = left_q - 8'd1;
            end
            S_BUF_CONFIRM: if (wr_en) begin
                if (cmd != C_CONFIRM) begin
                    st_set  = ST_SEQ_ERR;
                    state_d = S_STATUS;
                end else if (hit_q && !wp) begin
                    st_set  = ST_PGM_FAIL | ST_LOCK_VIOL;
                    state_d = S_STATUS;
                end else begin
                    op_d    = OP_BUF;
                    cnt_d   = '0;
                    state_d = S_BUSY;
                end
            end
            S_ERS_SETUP: if (wr_en) begin
                if (cmd != C_CONFIRM) begin
                    st_set  = ST_SEQ_ERR;
                    state_d = S_STATUS;
                end else if (wr_locked && !wp) begin
                    st_set  = ST_ERS_FAIL | ST_LOCK_VIOL;
                    state_d = S_STATUS;
                end else begin
                    op_d       = OP_ERS;
                    tgt_addr_d = wr_addr;
                    cnt_d      = '0;
                    state_d    = S_BUSY;
                end
            end
            S_LCK_SETUP: if (wr_en) begin
                state_d = S_STATUS;
                case (cmd)
                    C_LOCK_SET: if (!wp) st_set = ST_PGM_FAIL | ST_LOCK_VIOL;
                                else begin
                                    op_d       = OP_LSET;
                                    tgt_addr_d = wr_addr;
                                    cnt_d      = '0;
                                    state_d    = S_BUSY;
                                end
                    C_CONFIRM:  if (!wp) st_set = ST_ERS_FAIL | ST_LOCK_VIOL;
                                else begin
                                    op_d    = OP_LCLR;
                                    cnt_d   = '0;
                                    state_d = S_BUSY;
                                end
                    default:    st_set = ST_SEQ_ERR;
                endcase
            end
            S_BUSY: begin
                cnt_d = cnt_q + 1'b1;
                if (at_last) begin
                    op_d    = OP_NONE;
                    cnt_d   = '0;
                    state_d = S_STATUS;
                end
            end
            default: state_d = S_ARRAY;
        endcase
    end

    // outputs: array strobes and read mux
    always_comb begin
        a_pgm      = 1'b0;
        a_pgm_addr = tgt_addr_q;
        a_pgm_data = tgt_data_q;
        a_ers      = 1'b0;
        a_lset     = 1'b0;
        a_lclr     = 1'b0;
        if (busy) begin
            case (op_q)
                OP_PGM:  a_pgm = at_last;
                OP_BUF:  if (cnt_q < CYC_W'(buf_cnt)) begin
                             a_pgm      = 1'b1;
                             a_pgm_addr = buf_rd_addr;
                             a_pgm_data = buf_rd_data;
                         end
                OP_ERS:  a_ers  = at_last;
                OP_LSET: a_lset = at_last;
                OP_LCLR: a_lclr = at_last;
                default: ;
            endcase
        end
        if (state_q == S_ARRAY)          rd_data = arr_rd;
        else if (state_q == S_BUF_COUNT) rd_data = {{(DATA_W-8){1'b0}}, ST_READY};
        else                             rd_data = {{(DATA_W-8){1'b0}}, status};
    end

    fci_array #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .pgm_en   (a_pgm),
        .pgm_addr (a_pgm_addr),
        .pgm_data (a_pgm_data),
        .ers_en   (a_ers),
        .ers_blk  (tgt_blk),
        .lset_en  (a_lset),
        .lset_blk (tgt_blk),
        .lclr_en  (a_lclr),
        .rd_addr  (rd_addr),
        .rd_data  (arr_rd),
        .lock_n   (lock_n)
    );

    fci_wbuf #(.DEPTH(BUF_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (buf_clr),
        .push_i    (buf_push),
        .push_addr (wr_addr),
        .push_data (wr_data),
        .rd_idx    (IDX_W'(cnt_q)),
        .rd_addr   (buf_rd_addr),
        .rd_data   (buf_rd_data),
        .count_o   (buf_cnt)
    );

    fci_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (st_set),
        .clr_i    (st_clr),
        .ready_i  (!busy),
        .status_o (status)
    );

    // R8: busy runs its full length
    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BUSY && cnt_q != LAST) |=> (state_q == S_BUSY))
        else $error("a_r8_busy_holds");

    // R8: end of an operation lands in status mode
    a_r8_ends_in_status: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BUSY && cnt_q == LAST) |=> (state_q == S_STATUS))
        else $error("a_r8_ends_in_status");

    // R6: program to a locked block with wp low is refused
    a_r6_locked_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PGM_SETUP && wr_en && !wp && !lock_n[wr_blk])
        |=> (state_q == S_STATUS && status[4] && status[1]))
        else $error("a_r6_locked_refused");

    // R2: reserved codes leave the idle mode untouched
    a_r2_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_ARRAY || state_q == S_STATUS) && wr_en && !is_idle_cmd(wr_data[7:0]))
        |=> (state_q == $past(state_q)))
        else $error("a_r2_reserved_ignored");

endmodule

// File: tb/flash_cmd_if_bench.sv
module flash_cmd_if_bench;
    localparam int ADDR_W = 6;
    localparam int OFF_W  = 4;
    localparam int DATA_W = 16;
    localparam int BUF_DEPTH = 16;
    localparam int OP_CYCLES = 20;
    localparam int WORDS = 1 << ADDR_W;
    localparam int BLKW  = 1 << OFF_W;

    logic clk = 1'b0;
    logic rst_n, wr_en, wp;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_data;
    logic busy;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [15:0] ref_mem [WORDS];
    logic [15:0] v;

    always #10 clk = ~clk;

    flash_cmd_if #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W),
                   .BUF_DEPTH(BUF_DEPTH), .OP_CYCLES(OP_CYCLES)) u_flash_cmd_if (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wp(wp), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL R8 watchdog: actual %0d cycles expected fewer", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic [15:0] pat(input int a, input int s);
        return 16'(a * 1121 + s * 4099) ^ 16'hA5A5;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bw(input int a, input logic [15:0] d);
        @(negedge clk);
        wr_addr = ADDR_W'(a); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] val);
        rd_addr = ADDR_W'(a);
        #1;
        val = rd_data;
    endtask

    task automatic wait_ready;
        while (busy) @(negedge clk);
    endtask

    task automatic expect_status(input string tag, input logic [15:0] exp);
        logic [15:0] s;
        bw(0, 16'h0070);
        rd(0, s);
        check(tag, s, exp);
    endtask

    task automatic verify_range(input string tag, input int lo, input int hi);
        logic [15:0] w;
        bw(0, 16'h00FF);
        for (int a = lo; a <= hi; a++) begin
            rd(a, w);
            check(tag, w, ref_mem[a]);
        end
    endtask

    task automatic erase_blk(input int b);
        bw(b * BLKW, 16'h0020);
        bw(b * BLKW, 16'h00D0);
        wait_ready;
        for (int a = b * BLKW; a < (b + 1) * BLKW; a++) ref_mem[a] = 16'hFFFF;
    endtask

    task automatic program_word(input int a, input logic [15:0] d);
        bw(a, 16'h0040);
        bw(a, d);
        wait_ready;
        ref_mem[a] = ref_mem[a] & d;
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wp = 1'b0;
        wr_addr = '0; wr_data = '0; rd_addr = '0;
        for (int a = 0; a < WORDS; a++) ref_mem[a] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 busy after reset", {15'd0, busy}, 16'h0000);
        rd(0, v);  check("R1 word 0 erased", v, 16'hFFFF);
        rd(63, v); check("R1 word 63 erased", v, 16'hFFFF);
        expect_status("R1 reset status", 16'h0080);

        // R2 reserved codes and upper byte
        bw(0, 16'h0033);
        rd(5, v); check("R2 reserved code keeps status mode", v, 16'h0080);
        bw(0, 16'hFF00);
        rd(5, v); check("R2 upper byte ignored", v, 16'h0080);
        bw(0, 16'h70FF);
        rd(5, v); check("R10 low byte FFh selects array", v, 16'hFFFF);
        bw(0, 16'h0077);
        rd(5, v); check("R2 reserved code keeps array mode", v, 16'hFFFF);

        // R3 single program over every word, both setup codes
        for (int a = 0; a < WORDS; a++) begin
            bw(a, (a % 2 == 1) ? 16'hC340 : 16'h9A10);
            bw(a, pat(a, 0));
            if (a == 0) begin
                check("R8 busy after accepted program", {15'd0, busy}, 16'h0001);
                rd(0, v); check("R8 status reads not ready", v, 16'h0000);
            end
            if (a == 5) begin
                bw(16, 16'h0020);
                bw(16, 16'h00D0);
            end
            wait_ready;
            ref_mem[a] = pat(a, 0);
            if (a == 0) begin
                rd(0, v); check("R8 status mode after busy", v, 16'h0080);
            end
        end
        verify_range("R3 programmed word", 0, WORDS - 1);
        program_word(7, 16'h0FF0);
        verify_range("R3 program ANDs into word", 7, 7);

        // R5 erase
        erase_blk(1);
        verify_range("R5 erase affects only its block", 0, WORDS - 1);
        bw(40, 16'h0020);
        bw(40, 16'h0077);
        expect_status("R5 bad erase confirm", 16'h0088);
        verify_range("R5 bad confirm erases nothing", 32, 47);
        bw(0, 16'h0050);
        expect_status("R9 clear status", 16'h0080);

        // R4 buffered program over every count
        for (int n = 0; n < BUF_DEPTH; n++) begin
            erase_blk(2);
            bw(32, 16'h00E8);
            rd(0, v); check("R4 buffer free reads 0080h", v, 16'h0080);
            bw(32, 16'(n));
            for (int i = 0; i <= n; i++) begin
                int a;
                a = 32 + ((i * 5 + n) % BLKW);
                bw(a, pat(a, n + 1));
                ref_mem[a] = pat(a, n + 1);
            end
            bw(32, 16'h00D0);
            wait_ready;
            verify_range("R4 buffered words", 32, 47);
        end
        erase_blk(3);
        bw(48, 16'h00E8);
        bw(48, 16'h0002);
        for (int i = 0; i < 3; i++) bw(48 + i, 16'h1234);
        bw(48, 16'h0040);
        expect_status("R4 abort at confirm", 16'h0088);
        verify_range("R4 abort leaves array", 48, 50);
        bw(0, 16'h0050);
        bw(48, 16'h00E8);
        bw(48, 16'(BUF_DEPTH));
        expect_status("R4 count too large", 16'h0088);
        bw(0, 16'h0050);

        // R7 lock set refused with wp low
        wp = 1'b0;
        bw(0, 16'h0060);
        bw(0, 16'h0001);
        expect_status("R7 lock set with wp low", 16'h0092);
        bw(0, 16'h0050);
        program_word(1, 16'hF0F0);
        expect_status("R7 block stayed unlocked", 16'h0080);
        verify_range("R7 block stayed unlocked", 1, 1);

        // R7 lock set with wp high
        wp = 1'b1;
        bw(3, 16'h0060);
        bw(3, 16'h0001);
        check("R7 lock set runs", {15'd0, busy}, 16'h0001);
        wait_ready;
        expect_status("R7 lock set status", 16'h0080);
        wp = 1'b0;

        // R6 refusals on locked block 0
        bw(2, 16'h0010);
        bw(2, 16'h0000);
        check("R6 refused program no busy", {15'd0, busy}, 16'h0000);
        expect_status("R6 refused program", 16'h0092);
        bw(0, 16'h0050);
        bw(0, 16'h0020);
        bw(0, 16'h00D0);
        expect_status("R6 refused erase", 16'h00A2);
        bw(0, 16'h0050);
        bw(4, 16'h00E8);
        bw(4, 16'h0000);
        bw(4, 16'h0000);
        bw(4, 16'h00D0);
        expect_status("R6 refused buffered program", 16'h0092);
        bw(0, 16'h0050);
        verify_range("R6 locked block unchanged", 0, 15);
        program_word(60, 16'h00FF);
        verify_range("R7 other block not locked", 60, 60);
        wp = 1'b1;
        program_word(2, 16'h0F0F);
        verify_range("R6 wp high allows locked block", 2, 2);
        wp = 1'b0;

        // R9 sticky accumulation
        bw(0, 16'h0020);
        bw(0, 16'h00D0);
        bw(0, 16'h0060);
        bw(0, 16'h0033);
        expect_status("R9 failures accumulate", 16'h00AA);
        bw(0, 16'h0050);
        expect_status("R9 clear after accumulate", 16'h0080);

        // R7 lock clear
        bw(0, 16'h0060);
        bw(0, 16'h00D0);
        expect_status("R7 lock clear with wp low", 16'h00A2);
        bw(0, 16'h0050);
        bw(8, 16'h0040);
        bw(8, 16'h0000);
        expect_status("R7 lock kept after refused clear", 16'h0092);
        bw(0, 16'h0050);
        wp = 1'b1;
        bw(0, 16'h0060);
        bw(0, 16'h00D0);
        wait_ready;
        wp = 1'b0;
        erase_blk(0);
        expect_status("R7 cleared block erases with wp low", 16'h0080);
        verify_range("R7 cleared block erased", 0, WORDS - 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule